// File: doc/BRIEF.md
# Pipeline Hazard and Flush Controller

This block produces the stall, flush and redirect controls for a four-stage in-order integer pipeline with fetch, decode, execute and writeback stages. The decode and execute stages report register indices, write enables, a load marker, jump, fence and branch-outcome flags, and multi-cycle busy flags. From these the controller decides, in the same cycle, which stages hold their contents and which stages are emptied. It also decides whether the fetch unit must restart at a new address.

Jumps resolve in decode and empty only the fetch stage. Taken branches resolve in execute and empty both fetch and decode. An instruction-cache fence counts as a jump to the address of the instruction after it. The controller inserts a one-cycle bubble in two cases: a load whose result the next instruction reads, and an indirect jump whose base register the instruction just ahead of it writes. A busy multi-cycle operation freezes its own stage and every stage before it. All outputs are combinational from the current inputs, so the fetch unit sees the restart address in the cycle the jump sits in decode.

Top module: `hzc_top`

## Requirements
- R1: With no valid instruction in decode or execute and no busy flag set, every stall, flush, bubble and redirect output is 0.
- R2: When execute holds a valid load (ex_load_i=1, ex_wr_en_i=1) with a nonzero destination, and a valid decode instruction reads that register through an operand whose used flag is 1 (rs1 or rs2), stall_if_o, stall_id_o and bubble_ex_o are 1, and stall_ex_o and redirect_o are 0.
- R3: The load-use bubble lasts one cycle. Once execute holds no valid instruction, the same decode instruction raises no stall.
- R4: A destination of register 0, an operand whose used flag is 0, or a result from a non-load instruction never raises a stall.
- R5: A decode jump with id_jalr_i=1 whose rs1 equals the nonzero destination of a valid writing instruction in execute gets a one-cycle bubble (stall_if_o, stall_id_o, bubble_ex_o = 1) and no redirect. Once the dependency is gone, the jump redirects.
- R6: A valid decode jump with no dependency and no busy flag sets redirect_o=1 with redirect_pc_o = id_jump_tgt_i and flush_if_o=1, in the same cycle, with flush_id_o=0 and no stall.
- R7: A valid decode fence (id_fence_i=1) redirects to id_next_pc_i with flush_if_o=1 and flush_id_o=0.
- R8: A valid execute instruction with ex_br_taken_i=1 sets redirect_o=1, redirect_pc_o = ex_br_tgt_i, flush_if_o=1 and flush_id_o=1.
- R9: A valid execute branch with ex_br_taken_i=0 causes no stall, no flush and no redirect.
- R10: When a taken branch and a decode jump occur together, the branch wins: the redirect address is ex_br_tgt_i and flush_id_o=1.
- R11: ex_busy_i=1 or wb_busy_i=1 sets stall_if_o, stall_id_o and stall_ex_o to 1, with bubble_ex_o, flush_if_o, flush_id_o and redirect_o all 0. A decode jump waits, and a hazard inserts no bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used by the embedded checks) |
| rst_n | input | 1 | Active-low reset (disables the embedded checks) |
| id_valid_i | input | 1 | Decode stage holds a valid instruction |
| id_rs1_i | input | REG_AW | Decode first source register |
| id_rs2_i | input | REG_AW | Decode second source register |
| id_rs1_used_i | input | 1 | Decode instruction reads rs1 |
| id_rs2_used_i | input | 1 | Decode instruction reads rs2 |
| id_jump_i | input | 1 | Decode instruction is an unconditional jump |
| id_jalr_i | input | 1 | The jump is register-indirect |
| id_fence_i | input | 1 | Decode instruction is an instruction fence |
| id_jump_tgt_i | input | PC_W | Jump target address |
| id_next_pc_i | input | PC_W | Address of the instruction after the decode instruction |
| ex_valid_i | input | 1 | Execute stage holds a valid instruction |
| ex_rd_i | input | REG_AW | Execute destination register |
| ex_wr_en_i | input | 1 | Execute instruction writes its destination |
| ex_load_i | input | 1 | Execute instruction is a load |
| ex_br_taken_i | input | 1 | Execute branch condition met |
| ex_br_tgt_i | input | PC_W | Branch target address |
| ex_busy_i | input | 1 | Multi-cycle operation in execute not done |
| wb_busy_i | input | 1 | Writeback waiting on the data side |
| stall_if_o | output | 1 | Hold fetch |
| stall_id_o | output | 1 | Hold decode |
| stall_ex_o | output | 1 | Hold execute |
| flush_if_o | output | 1 | Empty fetch and its prefetch buffer |
| flush_id_o | output | 1 | Empty decode |
| bubble_ex_o | output | 1 | Clear the execute valid bit on the next edge |
| redirect_o | output | 1 | Fetch restart request |
| redirect_pc_o | output | PC_W | Fetch restart address |

## Verification
Every output follows the current inputs within one cycle, so an internal error shows at the ports in the cycle of the stimulus. A dependency comparator that matches on the wrong register or on register 0 shows as a stray stall_id_o/bubble_ex_o pair. A broken priority between branch and jump shows as the jump target on redirect_pc_o together with flush_id_o low. A missing busy gate shows as a redirect or a bubble while stall_ex_o is high.

// File: rtl/hzc_pkg.sv
package hzc_pkg;
  typedef enum logic [1:0] {
    REDIR_NONE   = 2'd0,
    REDIR_JUMP   = 2'd1,
    REDIR_FENCE  = 2'd2,
    REDIR_BRANCH = 2'd3
  } redir_src_e;

  typedef struct packed {
    logic stall_if;
    logic stall_id;
    logic stall_ex;
    logic bubble_ex;
  } stall_ctl_t;
endpackage

// File: rtl/hzc_dep_detect.sv
module hzc_dep_detect #(
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              id_valid_i,
  input  logic [REG_AW-1:0] id_rs1_i,
  input  logic [REG_AW-1:0] id_rs2_i,
  input  logic              id_rs1_used_i,
  input  logic              id_rs2_used_i,
  input  logic              id_jalr_i,
  input  logic              ex_valid_i,
  input  logic [REG_AW-1:0] ex_rd_i,
  input  logic              ex_wr_en_i,
  input  logic              ex_load_i,
  output logic              load_use_o,
  output logic              jalr_dep_o
);
  // Operand depends on the execute result; register 0 is never a producer.
  function automatic logic reads_dest(input logic used,
                                      input logic [REG_AW-1:0] rs,
                                      input logic [REG_AW-1:0] rd);
    return used && (rs == rd) && (rd != '0);
  endfunction

  logic ex_writes;
  logic rs1_hit;
  logic rs2_hit;

  assign ex_writes  = ex_valid_i & ex_wr_en_i;
  assign rs1_hit    = ex_writes & reads_dest(id_rs1_used_i, id_rs1_i, ex_rd_i);
  assign rs2_hit    = ex_writes & reads_dest(id_rs2_used_i, id_rs2_i, ex_rd_i);
  assign load_use_o = id_valid_i & ex_load_i & (rs1_hit | rs2_hit);
  assign jalr_dep_o = id_valid_i & id_jalr_i & rs1_hit;

  assert_x0_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rd_i == '0) |-> (!load_use_o && !jalr_dep_o));
  assert_load_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_use_o |-> (ex_load_i && ex_valid_i && id_valid_i));
endmodule

// File: rtl/hzc_redirect_arb.sv
module hzc_redirect_arb
  import hzc_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            branch_req_i,
  input  logic            jump_req_i,
  input  logic            fence_sel_i,
  input  logic [PC_W-1:0] branch_tgt_i,
  input  logic [PC_W-1:0] jump_tgt_i,
  input  logic [PC_W-1:0] next_pc_i,
  output redir_src_e      src_o,
  output logic            redirect_o,
  output logic [PC_W-1:0] redirect_pc_o,
  output logic            flush_if_o,
  output logic            flush_id_o
);
  // The older instruction (execute) wins over the younger one (decode).
  always_comb begin
    if (branch_req_i)     src_o = REDIR_BRANCH;
    else if (jump_req_i)  src_o = fence_sel_i ? REDIR_FENCE : REDIR_JUMP;
    else                  src_o = REDIR_NONE;
  end

  always_comb begin
    unique case (src_o)
      REDIR_BRANCH: redirect_pc_o = branch_tgt_i;
      REDIR_FENCE:  redirect_pc_o = next_pc_i;
      REDIR_JUMP:   redirect_pc_o = jump_tgt_i;
      default:      redirect_pc_o = '0;
    endcase
  end

  assign redirect_o = (src_o != REDIR_NONE);
  assign flush_if_o = redirect_o;
  assign flush_id_o = (src_o == REDIR_BRANCH);

  assert_branch_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (branch_req_i && jump_req_i) |-> (redirect_pc_o == branch_tgt_i && flush_id_o));
  assert_branch_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    branch_req_i |-> (flush_if_o && flush_id_o && redirect_o));
  assert_fence_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (jump_req_i && fence_sel_i && !branch_req_i) |-> (redirect_pc_o == next_pc_i && !flush_id_o));
endmodule

// File: rtl/hzc_stall_gen.sv
module hzc_stall_gen
  import hzc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ex_busy_i,
  input  logic       wb_busy_i,
  input  logic       hazard_i,
  input  logic       branch_req_i,
  output stall_ctl_t ctl_o
);
  logic hold;
  logic bubble;

  assign hold   = ex_busy_i | wb_busy_i;
  assign bubble = hazard_i & ~hold & ~branch_req_i;

  always_comb begin
    ctl_o.stall_ex  = hold;
    ctl_o.stall_id  = hold | bubble;
    ctl_o.stall_if  = hold | bubble;
    ctl_o.bubble_ex = bubble;
  end

  assert_hold_all_R11: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> (ctl_o.stall_if && ctl_o.stall_id && ctl_o.stall_ex && !ctl_o.bubble_ex));
  assert_bubble_moves_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_o.bubble_ex |-> (!ctl_o.stall_ex && ctl_o.stall_id));
endmodule

// File: rtl/hzc_top.sv
module hzc_top
  import hzc_pkg::*;
#(
  parameter int REG_AW = 5,
  parameter int PC_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              id_valid_i,
  input  logic [REG_AW-1:0] id_rs1_i,
  input  logic [REG_AW-1:0] id_rs2_i,
  input  logic              id_rs1_used_i,
  input  logic              id_rs2_used_i,
  input  logic              id_jump_i,
  input  logic              id_jalr_i,
  input  logic              id_fence_i,
  input  logic [PC_W-1:0]   id_jump_tgt_i,
  input  logic [PC_W-1:0]   id_next_pc_i,
  input  logic              ex_valid_i,
  input  logic [REG_AW-1:0] ex_rd_i,
  input  logic              ex_wr_en_i,
  input  logic              ex_load_i,
  input  logic              ex_br_taken_i,
  input  logic [PC_W-1:0]   ex_br_tgt_i,
  input  logic              ex_busy_i,
  input  logic              wb_busy_i,
  output logic              stall_if_o,
  output logic              stall_id_o,
  output logic              stall_ex_o,
  output logic              flush_if_o,
  output logic              flush_id_o,
  output logic              bubble_ex_o,
  output logic              redirect_o,
  output logic [PC_W-1:0]   redirect_pc_o
);
  // Named internal events
  logic       load_use_w;
  logic       jalr_dep_w;
  logic       hold_w;
  logic       branch_req_w;
  logic       jump_req_w;
  redir_src_e src_w;
  stall_ctl_t ctl_w;

  hzc_dep_detect #(.REG_AW(REG_AW)) u_dep (
    .clk(clk), .rst_n(rst_n),
    .id_valid_i(id_valid_i), .id_rs1_i(id_rs1_i), .id_rs2_i(id_rs2_i),
    .id_rs1_used_i(id_rs1_used_i), .id_rs2_used_i(id_rs2_used_i),
    .id_jalr_i(id_jalr_i),
    .ex_valid_i(ex_valid_i), .ex_rd_i(ex_rd_i), .ex_wr_en_i(ex_wr_en_i),
    .ex_load_i(ex_load_i),
    .load_use_o(load_use_w), .jalr_dep_o(jalr_dep_w)
  );

  assign hold_w       = ex_busy_i | wb_busy_i;
  assign branch_req_w = ex_valid_i & ex_br_taken_i & ~hold_w;
  assign jump_req_w   = id_valid_i & (id_jump_i | id_fence_i) & ~jalr_dep_w & ~hold_w;

  hzc_stall_gen u_stall (
    .clk(clk), .rst_n(rst_n),
    .ex_busy_i(ex_busy_i), .wb_busy_i(wb_busy_i),
    .hazard_i(load_use_w | jalr_dep_w),
    .branch_req_i(branch_req_w),
    .ctl_o(ctl_w)
  );

  hzc_redirect_arb #(.PC_W(PC_W)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .branch_req_i(branch_req_w), .jump_req_i(jump_req_w),
    .fence_sel_i(id_fence_i),
    .branch_tgt_i(ex_br_tgt_i), .jump_tgt_i(id_jump_tgt_i), .next_pc_i(id_next_pc_i),
    .src_o(src_w), .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o),
    .flush_if_o(flush_if_o), .flush_id_o(flush_id_o)
  );

  assign stall_if_o  = ctl_w.stall_if;
  assign stall_id_o  = ctl_w.stall_id;
  assign stall_ex_o  = ctl_w.stall_ex;
  assign bubble_ex_o = ctl_w.bubble_ex;

  assert_load_bubble_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_use_w && !stall_ex_o && !flush_id_o) |-> (stall_if_o && stall_id_o && bubble_ex_o && !redirect_o));
  assert_jalr_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    jalr_dep_w |-> (!redirect_o || flush_id_o));
  assert_jump_now_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid_i && id_jump_i && !id_fence_i && !jalr_dep_w && !stall_ex_o && !branch_req_w)
      |-> (redirect_o && redirect_pc_o == id_jump_tgt_i && !flush_id_o && !stall_id_o));
  assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ex_br_taken_i && !(id_valid_i && (id_jump_i || id_fence_i))) |-> (!redirect_o && !flush_id_o && !flush_if_o));
  assert_busy_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stall_ex_o |-> (!redirect_o && !bubble_ex_o && stall_if_o));
  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!id_valid_i && !ex_valid_i && !ex_busy_i && !wb_busy_i)
      |-> ({stall_if_o, stall_id_o, stall_ex_o, flush_if_o, flush_id_o, bubble_ex_o, redirect_o} == 7'b0));
endmodule

// File: tb/hzc_top_test.sv
module hzc_top_test;
  localparam int REG_AW = 5;
  localparam int PC_W   = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic id_valid_i, id_rs1_used_i, id_rs2_used_i, id_jump_i, id_jalr_i, id_fence_i;
  logic [REG_AW-1:0] id_rs1_i, id_rs2_i, ex_rd_i;
  logic [PC_W-1:0] id_jump_tgt_i, id_next_pc_i, ex_br_tgt_i, redirect_pc_o;
  logic ex_valid_i, ex_wr_en_i, ex_load_i, ex_br_taken_i, ex_busy_i, wb_busy_i;
  logic stall_if_o, stall_id_o, stall_ex_o, flush_if_o, flush_id_o, bubble_ex_o, redirect_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  hzc_top #(.REG_AW(REG_AW), .PC_W(PC_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .id_valid_i(id_valid_i), .id_rs1_i(id_rs1_i), .id_rs2_i(id_rs2_i),
    .id_rs1_used_i(id_rs1_used_i), .id_rs2_used_i(id_rs2_used_i),
    .id_jump_i(id_jump_i), .id_jalr_i(id_jalr_i), .id_fence_i(id_fence_i),
    .id_jump_tgt_i(id_jump_tgt_i), .id_next_pc_i(id_next_pc_i),
    .ex_valid_i(ex_valid_i), .ex_rd_i(ex_rd_i), .ex_wr_en_i(ex_wr_en_i),
    .ex_load_i(ex_load_i), .ex_br_taken_i(ex_br_taken_i), .ex_br_tgt_i(ex_br_tgt_i),
    .ex_busy_i(ex_busy_i), .wb_busy_i(wb_busy_i),
    .stall_if_o(stall_if_o), .stall_id_o(stall_id_o), .stall_ex_o(stall_ex_o),
    .flush_if_o(flush_if_o), .flush_id_o(flush_id_o), .bubble_ex_o(bubble_ex_o),
    .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o)
  );

  // Output vector order: stall_if, stall_id, stall_ex, flush_if, flush_id, bubble_ex, redirect
  task automatic check_ctl(input string req, input logic [6:0] exp);
    logic [6:0] act;
    act = {stall_if_o, stall_id_o, stall_ex_o, flush_if_o, flush_id_o, bubble_ex_o, redirect_o};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: controls actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic check_pc(input string req, input logic [PC_W-1:0] exp);
    checks++;
    if (redirect_pc_o !== exp) begin
      errors++;
      $display("FAIL %s: redirect pc actual %h expected %h", req, redirect_pc_o, exp);
    end
  endtask

  task automatic idle_inputs();
    id_valid_i = 0; id_rs1_i = 0; id_rs2_i = 0; id_rs1_used_i = 0; id_rs2_used_i = 0;
    id_jump_i = 0; id_jalr_i = 0; id_fence_i = 0;
    id_jump_tgt_i = 32'h0000_1000; id_next_pc_i = 32'h0000_0204;
    ex_valid_i = 0; ex_rd_i = 0; ex_wr_en_i = 0; ex_load_i = 0;
    ex_br_taken_i = 0; ex_br_tgt_i = 32'h0000_3000; ex_busy_i = 0; wb_busy_i = 0;
  endtask

  // Drive after the edge, sample mid-cycle
  task automatic next_cycle();
    @(posedge clk); #2;
  endtask
  task automatic settle();
    #8;
  endtask

  task automatic t_reset_idle();
    next_cycle(); idle_inputs(); settle();
    check_ctl("R1 idle after reset", 7'b0000000);
  endtask

  task automatic t_load_use();
    next_cycle(); idle_inputs();
    ex_valid_i = 1; ex_load_i = 1; ex_wr_en_i = 1; ex_rd_i = 5'd5;
    id_valid_i = 1; id_rs1_i = 5'd5; id_rs1_used_i = 1; settle();
    check_ctl("R2 load-use on rs1", 7'b1100010);
    next_cycle(); ex_valid_i = 0; settle();  // bubble now in execute
    check_ctl("R3 single bubble", 7'b0000000);
    next_cycle(); idle_inputs();
    ex_valid_i = 1; ex_load_i = 1; ex_wr_en_i = 1; ex_rd_i = 5'd9;
    id_valid_i = 1; id_rs1_i = 5'd3; id_rs1_used_i = 1; id_rs2_i = 5'd9; id_rs2_used_i = 1; settle();
    check_ctl("R2 load-use on rs2", 7'b1100010);
  endtask

  task automatic t_no_dep();
    next_cycle(); idle_inputs();
    ex_valid_i = 1; ex_load_i = 1; ex_wr_en_i = 1; ex_rd_i = 5'd0;
    id_valid_i = 1; id_rs1_i = 5'd0; id_rs1_used_i = 1; settle();
    check_ctl("R4 register 0 load", 7'b0000000);
    ex_rd_i = 5'd6; id_rs1_i = 5'd1; id_rs2_i = 5'd6; id_rs2_used_i = 0; #1;
    check_ctl("R4 unused operand", 7'b0000000);
    ex_load_i = 0; id_rs2_used_i = 1; #1;
    check_ctl("R4 non-load producer", 7'b0000000);
  endtask

  task automatic t_jalr_dep();
    next_cycle(); idle_inputs();
    ex_valid_i = 1; ex_wr_en_i = 1; ex_rd_i = 5'd7;
    id_valid_i = 1; id_jump_i = 1; id_jalr_i = 1; id_rs1_i = 5'd7; id_rs1_used_i = 1;
    id_jump_tgt_i = 32'h0000_4440; settle();
    check_ctl("R5 jalr dependency bubble", 7'b1100010);
    next_cycle(); ex_valid_i = 0; settle();
    check_ctl("R5 jalr redirects after bubble", 7'b0001001);
    check_pc("R5 jalr target", 32'h0000_4440);
  endtask

  task automatic t_jump();
    next_cycle(); idle_inputs();
    id_valid_i = 1; id_jump_i = 1; id_jump_tgt_i = 32'h0000_8000; settle();
    check_ctl("R6 jump redirect", 7'b0001001);
    check_pc("R6 jump target", 32'h0000_8000);
  endtask

  task automatic t_fence();
    next_cycle(); idle_inputs();
    id_valid_i = 1; id_fence_i = 1; id_jump_tgt_i = 32'h0000_9999; id_next_pc_i = 32'h0000_0a04; settle();
    check_ctl("R7 fence redirect", 7'b0001001);
    check_pc("R7 fence next address", 32'h0000_0a04);
  endtask

  task automatic t_branch();
    next_cycle(); idle_inputs();
    ex_valid_i = 1; ex_br_taken_i = 1; ex_br_tgt_i = 32'h0000_c0c0;
    id_valid_i = 1; id_rs1_i = 5'd2; id_rs1_used_i = 1; settle();
    check_ctl("R8 taken branch", 7'b0001101);
    check_pc("R8 branch target", 32'h0000_c0c0);
    next_cycle(); ex_br_taken_i = 0; settle();
    check_ctl("R9 not-taken branch", 7'b0000000);
  endtask

  task automatic t_branch_vs_jump();
    next_cycle(); idle_inputs();
    ex_valid_i = 1; ex_br_taken_i = 1; ex_br_tgt_i = 32'h0000_d000;
    id_valid_i = 1; id_jump_i = 1; id_jump_tgt_i = 32'h0000_e000; settle();
    check_ctl("R10 branch over jump", 7'b0001101);
    check_pc("R10 branch target wins", 32'h0000_d000);
  endtask

  task automatic t_busy();
    next_cycle(); idle_inputs();
    ex_valid_i = 1; ex_busy_i = 1; ex_rd_i = 5'd4; ex_wr_en_i = 1;
    id_valid_i = 1; id_jump_i = 1; id_jump_tgt_i = 32'h0000_5000; settle();
    check_ctl("R11 execute busy holds jump", 7'b1110000);
    next_cycle(); idle_inputs();
    wb_busy_i = 1; ex_valid_i = 1; ex_load_i = 1; ex_wr_en_i = 1; ex_rd_i = 5'd8;
    id_valid_i = 1; id_rs1_i = 5'd8; id_rs1_used_i = 1; settle();
    check_ctl("R11 writeback busy, no bubble", 7'b1110000);
    next_cycle(); wb_busy_i = 0; settle();
    check_ctl("R2 load-use after release", 7'b1100010);
  endtask

  initial begin
    idle_inputs();
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    t_reset_idle();
    t_load_use();
    t_no_dep();
    t_jalr_dep();
    t_jump();
    t_fence();
    t_branch();
    t_branch_vs_jump();
    t_busy();
    next_cycle(); idle_inputs();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule